// File: doc/BRIEF.md
# Pipeline Activity-Based Clock Gating Controller

This block decides, cycle by cycle, whether the pipeline registers of a processor core receive their clock. It watches three kinds of pipeline event: a decoded halt instruction, an unbroken run of no-operation instructions, and a program counter that stops moving when the hazard logic has not asked for a stall. When any of these is seen, the block enters a low-power mode and stops the gated clock. In the active mode the gated clock follows the free-running clock.

The gated clock comes from a standard gating cell. An enable latch is open while the clock is low, and its output is ANDed with the clock, so the gated clock has no runt pulses. The block leaves low power on an external wake request. When low power was entered because of a run of no-ops, it also leaves as soon as an instruction that is not a no-op arrives. On every return to the active mode all run counters start again from zero.

A two-bit code records which event caused the most recent entry into low power. That code is kept until the next entry or a reset.

Top module: `pcg_top`

## Requirements
- R1: While rst_n is low the block is active: low_pwr_o is 0, cause_o is 2'b00, and gclk_o follows clk.
- R2: When halt_i is high in an active cycle, low_pwr_o is 1 from the next rising edge and cause_o reads 2'b01.
- R3: NOP_LIMIT consecutive active cycles with nop_i high and halt_i low set low_pwr_o to 1 at the last of those edges, with cause_o 2'b10. A cycle with nop_i low restarts the count, so NOP_LIMIT-1 no-ops followed by a non-no-op keep the block active.
- R4: PC_STALL_LIMIT consecutive active cycles with pc_adv_i low and hold_req_i low enter low power with cause_o 2'b11. A cycle with pc_adv_i high or hold_req_i high restarts the count.
- R5: When several entry conditions complete in the same cycle, the cause is chosen by priority: halt (2'b01) first, then no-op run (2'b10), then PC stall (2'b11).
- R6: In low power, wake_i high returns the block to the active mode at the next rising edge, whatever the cause.
- R7: Low power entered through a no-op run (cause 2'b10) is left at the next edge after a cycle with nop_i low. Low power from halt or PC stall ignores nop_i, halt_i, pc_adv_i and hold_req_i, and only wake_i or reset ends it.
- R8: On a return to the active mode both run counters restart at zero, so a full new run of NOP_LIMIT no-ops (or PC_STALL_LIMIT stall cycles) is needed to enter low power again.
- R9: A rising edge of clk produces a rising edge of gclk_o exactly when the block was active (or in reset) during the clock-low phase just before that edge. The first gated pulse after a return comes on the edge that follows the wake cycle.
- R10: cause_o keeps the code of the last entry after the block returns to active, until the next entry or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Decoded halt instruction at the watched stage |
| nop_i | input | 1 | Decoded no-op instruction at the watched stage |
| pc_adv_i | input | 1 | Program counter advanced this cycle |
| hold_req_i | input | 1 | Legitimate stall request from the hazard logic |
| wake_i | input | 1 | External wake or interrupt request |
| gclk_o | output | 1 | Gated clock for the pipeline registers |
| low_pwr_o | output | 1 | 1 while in low-power mode |
| cause_o | output | 2 | Cause of last entry: 01 halt, 10 no-op run, 11 PC stall, 00 none since reset |

## Verification
The properties assume that the event inputs are synchronous to clk and hold steady around each rising edge. They also assume that the gating latch is only loaded while clk is low, so gclk_o cannot change during the high phase. The bench changes every input on the falling edge and samples two nanoseconds after the rising edge, which meets both assumptions. The bench starts clk low, so the enable latch is loaded before the first rising edge.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_HALT    = 2'b01,
      CAUSE_NOPRUN  = 2'b10,
      CAUSE_PCSTALL = 2'b11
   } sleep_cause_e;
endpackage

// File: rtl/pcg_run_counter.sv
module pcg_run_counter #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("pcg_run_counter: LIMIT must be at least 2");
      end
   endgenerate

   // saturating run length; any break in the run clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr || !inc)      cnt_q <= '0;
      else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
   end

   assign hit = inc && (cnt_q == LAST);

   // R3 / R4: the run counter never passes its last step
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R8: a clear leaves the counter at zero
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);
endmodule

// File: rtl/pcg_mode_ctl.sv
module pcg_mode_ctl
   import pcg_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         halt_i,
   input  logic         nop_i,
   input  logic         wake_i,
   input  logic         nop_hit,
   input  logic         stall_hit,
   output logic         low_q,
   output logic         enter,
   output sleep_cause_e cause_q
);
   sleep_cause_e nxt_cause;
   logic         leave;

   always_comb begin
      nxt_cause = CAUSE_NONE;
      if (halt_i)         nxt_cause = CAUSE_HALT;
      else if (nop_hit)   nxt_cause = CAUSE_NOPRUN;
      else if (stall_hit) nxt_cause = CAUSE_PCSTALL;
   end

   assign enter = !low_q && (nxt_cause != CAUSE_NONE);
   assign leave = low_q && (wake_i || (cause_q == CAUSE_NOPRUN && !nop_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else if (enter) begin
         low_q   <= 1'b1;
         cause_q <= nxt_cause;
      end else if (leave) begin
         low_q   <= 1'b0;
      end
   end

   a_r2_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_q && halt_i) |=> (low_q && cause_q == CAUSE_HALT));

   a_r6_wake_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q && wake_i) |=> !low_q);

   a_r7_nop_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q && cause_q == CAUSE_NOPRUN && !nop_i) |=> !low_q);

   a_r7_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q && !wake_i && cause_q != CAUSE_NOPRUN) |=> low_q);

   a_r10_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_q && !enter) |=> $stable(cause_q));
endmodule

// File: rtl/pcg_clk_gate.sv
module pcg_clk_gate (
   input  logic clk,
   input  logic en_req,
   output logic gclk
);
   logic en_lat;

   // enable may only move while the clock is low
   always_latch begin
      if (!clk) en_lat = en_req;
   end

   assign gclk = clk & en_lat;
endmodule

// File: rtl/pcg_top.sv
module pcg_top
   import pcg_pkg::*;
#(
   parameter int NOP_LIMIT      = 16,
   parameter int PC_STALL_LIMIT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_i,
   input  logic       nop_i,
   input  logic       pc_adv_i,
   input  logic       hold_req_i,
   input  logic       wake_i,
   output logic       gclk_o,
   output logic       low_pwr_o,
   output logic [1:0] cause_o
);
   logic         low_q, enter, nop_hit, stall_hit, cnt_clr;
   sleep_cause_e cause_q;

   assign cnt_clr = low_q || enter;

   pcg_run_counter #(.LIMIT(NOP_LIMIT)) u_nop_run (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .inc(nop_i && !halt_i), .hit(nop_hit));

   pcg_run_counter #(.LIMIT(PC_STALL_LIMIT)) u_pc_stall (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .inc(!pc_adv_i && !hold_req_i), .hit(stall_hit));

   pcg_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .nop_i(nop_i),
      .wake_i(wake_i), .nop_hit(nop_hit), .stall_hit(stall_hit),
      .low_q(low_q), .enter(enter), .cause_q(cause_q));

   pcg_clk_gate u_gate (
      .clk(clk), .en_req(!low_q || !rst_n), .gclk(gclk_o));

   assign low_pwr_o = low_q;
   assign cause_o   = cause_q;
endmodule

// File: tb/pcg_top_test.sv
module pcg_top_test;
   localparam int NOPL = 16;
   localparam int PCL  = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic halt = 1'b0, nop = 1'b0, adv = 1'b1, hold = 1'b0, wake = 1'b0;
   logic gclk, lowp;
   logic [1:0] cause;

   int total = 0, bad = 0;
   bit m_low = 0;
   int m_cause = 0, m_nops = 0, m_stalls = 0;
   string tag = "R1";

   always #5 clk = ~clk;

   pcg_top #(.NOP_LIMIT(NOPL), .PC_STALL_LIMIT(PCL)) uut (
      .clk(clk), .rst_n(rst_n), .halt_i(halt), .nop_i(nop), .pc_adv_i(adv),
      .hold_req_i(hold), .wake_i(wake), .gclk_o(gclk), .low_pwr_o(lowp),
      .cause_o(cause));

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
      end
   endtask

   // one clock with given inputs, reference model step, then compare
   task automatic cyc(input bit h, input bit n, input bit a, input bit hd, input bit w);
      bit pre_act;
      @(negedge clk);
      halt = h; nop = n; adv = a; hold = hd; wake = w;
      @(posedge clk);
      #2;
      pre_act = !m_low;
      if (!rst_n) begin
         m_low = 0; m_cause = 0; m_nops = 0; m_stalls = 0; pre_act = 1;
      end else if (!m_low) begin
         m_nops   = (n && !h) ? m_nops + 1 : 0;
         m_stalls = (!a && !hd) ? m_stalls + 1 : 0;
         if (h)                   begin m_low = 1; m_cause = 1; end
         else if (m_nops >= NOPL) begin m_low = 1; m_cause = 2; end
         else if (m_stalls >= PCL) begin m_low = 1; m_cause = 3; end
         if (m_low) begin m_nops = 0; m_stalls = 0; end
      end else if (w || (m_cause == 2 && !n)) begin
         m_low = 0;
      end
      check(tag, 32'(lowp), 32'(m_low), "low_pwr_o");
      check(tag, 32'(cause), 32'(m_cause), "cause_o");
      check("R9", 32'(gclk), 32'(pre_act), "gclk_o");
   endtask

   task automatic run(input int k);   // normal flow
      for (int i = 0; i < k; i++) cyc(0, 0, 1, 0, 0);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 7;
      // R1 reset state
      tag = "R1";
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
      rst_n = 1'b1;
      run(3);
      // R2 halt entry, R7 halt ignores other inputs, R6 wake
      tag = "R2"; cyc(1, 0, 1, 0, 0);
      tag = "R7"; cyc(0, 0, 1, 0, 0); cyc(0, 1, 0, 1, 0); cyc(0, 0, 1, 0, 0);
      tag = "R6"; cyc(0, 0, 1, 0, 1);
      tag = "R10"; run(3);
      // R3 run of NOPL-1 broken, then full run
      tag = "R3";
      for (int i = 0; i < NOPL - 1; i++) cyc(0, 1, 1, 0, 0);
      cyc(0, 0, 1, 0, 0);
      for (int i = 0; i < NOPL; i++) cyc(0, 1, 1, 0, 0);
      cyc(0, 1, 1, 0, 0);
      // R7 non-NOP ends NOP-run low power
      tag = "R7"; cyc(0, 0, 1, 0, 0);
      // R8 counters restarted: NOPL-1 NOPs stay active
      tag = "R8";
      for (int i = 0; i < NOPL - 1; i++) cyc(0, 1, 1, 0, 0);
      cyc(0, 0, 1, 0, 0);
      // R4 stall runs: broken by advance, by hold, then full
      tag = "R4";
      for (int i = 0; i < PCL - 1; i++) cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 0);
      for (int i = 0; i < PCL - 1; i++) cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0);
      for (int i = 0; i < PCL; i++) cyc(0, 0, 0, 0, 0);
      tag = "R7"; cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
      tag = "R6"; cyc(0, 0, 0, 0, 1);
      // R5 priority: halt over NOP run
      tag = "R5";
      for (int i = 0; i < NOPL - 1; i++) cyc(0, 1, 0, 1, 0);
      cyc(1, 1, 1, 0, 0);
      cyc(0, 0, 1, 0, 1);
      // R5 priority: NOP run over PC stall
      for (int i = 0; i < NOPL - 1; i++) cyc(0, 1, i < NOPL - PCL, 0, 0);
      cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 1, 0, 0);
      // R1 reset while in low power
      tag = "R1";
      cyc(1, 0, 1, 0, 0);
      rst_n = 1'b0;
      cyc(0, 0, 1, 0, 0);
      rst_n = 1'b1;
      run(2);
      // mixed pseudo-random traffic
      tag = "R9";
      for (int i = 0; i < 1500; i++) begin
         int r;
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         r = seed >>> 8;
         cyc((r % 97) == 0, (r % 8) < 6, (r % 5) < 1, (r % 11) == 0, (r % 29) == 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule